// File: doc/BRIEF.md
# Speculative Dual-Threshold SAR Controller

This block sequences one two-comparator sub-converter of a sampling serial receiver. At the start of each sample period it loads two threshold codes that an upstream history table has predicted. One code is a guess for the level the sample would have if the transmitted bit were 1. The other is a guess for the level if the bit were 0. Both codes drive the threshold DACs. The bit is known as soon as the two comparators agree with each other. The block then spends the rest of the fixed iteration budget refining the matching threshold until its comparator flips, which gives a digitized level.

There is one sample per `sample_start` pulse. The edge that sees the pulse loads the seeds. The next five clock edges are evaluation cycles 1 to 5, and each one samples `cmp_hi`/`cmp_lo` against the codes currently on `dac_hi`/`dac_lo`. A comparator reads 1 when the held sample is at or above its threshold code. The edge of cycle 5 latches the results, which then stay unchanged until the next completed sample. A new pulse may land on the cycle-5 edge, which gives a sample period of five clocks. If no agreement or no digitization is reached in the budget, the block flags a calibration request so the prediction table can be corrected.

Top module: `spec_sar_ctrl`

## Requirements
- R1: While reset is held and on the first edge after its release, every output is 0, and both threshold codes are 0.
- R2: The edge that sees `sample_start` loads `spec_one` into `dac_hi` and `spec_zero` into `dac_lo`, clears the per-sample status and arms evaluation cycle 1 on the following edge.
- R3: In an evaluation cycle before the bit is known, `cmp_hi`=1 with `cmp_lo`=1 recovers bit 1, and `cmp_hi`=0 with `cmp_lo`=0 recovers bit 0. Once recovered, the bit stays fixed for the rest of the sample.
- R4: Before recovery, `cmp_hi`=0 with `cmp_lo`=1 lowers `dac_hi` by one and raises `dac_lo` by one. `cmp_hi`=1 with `cmp_lo`=0 moves neither code.
- R5: On the recovering cycle and on each later cycle until digitization, only the matching code moves. For bit 1, `dac_hi` rises by one. For bit 0, `dac_lo` falls by one. The other code holds.
- R6: After recovery, the digitized level is the matching code in the first cycle where that comparator has changed. For bit 1 this is `cmp_hi` reading 0, and for bit 0 it is `cmp_lo` reading 1. The result then reports `level_valid`=1.
- R7: `cal_req` is 1 exactly when a sample finishes cycle 5 without digitization, and then `level_valid` is 0. If recovery succeeded without digitization, `level_out` is the matching code presented in cycle 5.
- R8: If no recovery happens by cycle 5, `bit_valid` is 0. `bit_out` is 1 when the sum of the two codes presented in cycle 5 is at least 32, meaning their midpoint lies in the upper half of the code range. `level_out` is that sum divided by two, rounded down.
- R9: Both threshold codes saturate at 0 and 31 and never wrap.
- R10: The outputs change only on the cycle-5 edge. `result_stb` is 1 for exactly the one clock that follows that edge, and all outputs hold their values otherwise.
- R11: A `sample_start` that arrives during cycles 1 to 4 abandons the sample in progress without touching the outputs, and then starts a new sample.
- R12: A `sample_start` on the cycle-5 edge both latches the finishing sample's results and loads the new seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast iteration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_start | input | 1 | One-clock pulse that loads the seeds for a new sample |
| spec_one | input | 5 | Predicted threshold code for a transmitted 1 |
| spec_zero | input | 5 | Predicted threshold code for a transmitted 0 |
| cmp_hi | input | 1 | Comparator decision against `dac_hi` (1 = sample at or above) |
| cmp_lo | input | 1 | Comparator decision against `dac_lo` (1 = sample at or above) |
| dac_hi | output | 5 | Threshold code for the bit-1 search path |
| dac_lo | output | 5 | Threshold code for the bit-0 search path |
| bit_out | output | 1 | Recovered bit of the last completed sample |
| level_out | output | 5 | Digitized level of the last completed sample |
| bit_valid | output | 1 | Last sample recovered its bit by comparator agreement |
| level_valid | output | 1 | Last sample completed digitization |
| cal_req | output | 1 | Last sample ran out of cycles before digitization |
| result_stb | output | 1 | One-clock pulse after new results are latched |

## Verification
The assertions assume that the comparators report a single analog value held steady for the whole sample, measured against whatever codes the DAC outputs carry at each edge. They also assume that `sample_start` is a single-clock pulse. The bench keeps within this by computing both comparator inputs combinationally from one held sample code and the live DAC outputs. It changes that sample code only in the clock after a load edge, so every evaluation edge of one sample sees the same value. Back-to-back and aborted samples reuse the same held value, so the overlap of the load edge with the previous evaluations stays within the same assumption.

// File: rtl/ssc_pkg.sv
// Shared types for the speculative dual-threshold SAR controller.
package ssc_pkg;
    // Per-cycle move command for one threshold register.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/ssc_thresh_reg.sv
// One threshold code register feeding a DAC.
// Loads its seed on start, otherwise moves one code per step command and
// saturates at both ends of the code range. Assumes load wins over step.
module ssc_thresh_reg import ssc_pkg::*; #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  step_e        step,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

    // Seed load, saturating increment or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (load) begin
            code <= load_val;
        end else begin
            case (step)
                STEP_UP:   if (code != CODE_MAX) code <= code + 1'b1;
                STEP_DOWN: if (code != '0)       code <= code - 1'b1;
                default:   ;
            endcase
        end
    end

    // R9
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step == STEP_UP && code == CODE_MAX) |=> code == CODE_MAX);
    // R9
    sat_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step == STEP_DOWN && code == '0) |=> code == '0);
endmodule

// File: rtl/ssc_cycle_ctr.sv
// Iteration counter: 0 = idle, 1..NCYC = evaluation cycle number.
// A start pulse always re-arms cycle 1, including on the final cycle.
module ssc_cycle_ctr #(
    parameter int NCYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic eval_en,
    output logic last
);
    localparam int CW = $clog2(NCYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(NCYC);

    logic [CW-1:0] cnt;

    // Arm on start, advance during evaluation, fall idle after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= CW'(1);
        else if (cnt == CNT_LAST) cnt <= '0;
        else if (cnt != '0)    cnt <= cnt + 1'b1;
    end

    assign eval_en = (cnt != '0);
    assign last    = (cnt == CNT_LAST);

    // R2
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (eval_en && cnt == CW'(1)));
endmodule

// File: rtl/ssc_decide.sv
// Per-cycle decision logic and per-sample status (recovered, bit, digitized, level).
// Produces the step commands for both threshold registers and the next-state
// status that the result latch captures on the last cycle.
// Assumes both comparators see the same held sample for the whole period.
module ssc_decide import ssc_pkg::*; #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         eval_en,
    input  logic         c_hi,
    input  logic         c_lo,
    input  logic [W-1:0] code_hi,
    input  logic [W-1:0] code_lo,
    output step_e        step_hi,
    output step_e        step_lo,
    output logic         nx_rec,
    output logic         nx_bit,
    output logic         nx_dig,
    output logic [W-1:0] nx_lvl
);
    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

    logic         rec_q, bit_q, dig_q;
    logic [W-1:0] lvl_q;

    // Decide this cycle's moves and status updates.
    always_comb begin
        step_hi = STEP_HOLD;
        step_lo = STEP_HOLD;
        nx_rec  = rec_q;
        nx_bit  = bit_q;
        nx_dig  = dig_q;
        nx_lvl  = lvl_q;
        if (eval_en) begin
            if (!rec_q) begin
                if (c_hi && c_lo) begin
                    nx_rec  = 1'b1;
                    nx_bit  = 1'b1;
                    step_hi = STEP_UP;
                end else if (!c_hi && !c_lo) begin
                    nx_rec  = 1'b1;
                    nx_bit  = 1'b0;
                    step_lo = STEP_DOWN;
                end else if (!c_hi && c_lo) begin
                    step_hi = STEP_DOWN;
                    step_lo = STEP_UP;
                end
            end else if (!dig_q) begin
                if (bit_q) begin
                    if (!c_hi) begin
                        nx_dig = 1'b1;
                        nx_lvl = code_hi;
                    end else begin
                        step_hi = STEP_UP;
                    end
                end else begin
                    if (c_lo) begin
                        nx_dig = 1'b1;
                        nx_lvl = code_lo;
                    end else begin
                        step_lo = STEP_DOWN;
                    end
                end
            end
        end
    end

    // Status registers: cleared by a new sample, updated each evaluation cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            rec_q <= 1'b0;
            bit_q <= 1'b0;
            dig_q <= 1'b0;
            lvl_q <= '0;
        end else begin
            rec_q <= nx_rec;
            bit_q <= nx_bit;
            dig_q <= nx_dig;
            lvl_q <= nx_lvl;
        end
    end

    // R6
    dig_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_q |-> rec_q);
    // R3
    rec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q && !start) |=> (rec_q && bit_q == $past(bit_q)));
    // R4
    close_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && !start && !rec_q && !c_hi && c_lo && code_hi != '0 && code_lo != CODE_MAX)
        |=> (code_hi == W'($past(code_hi) - 1'b1) && code_lo == W'($past(code_lo) + 1'b1)));
    // R5
    refine_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && !start && rec_q && !dig_q && bit_q && c_hi && code_hi != CODE_MAX)
        |=> (code_hi == W'($past(code_hi) + 1'b1) && $stable(code_lo)));
endmodule

// File: rtl/ssc_result.sv
// Output latch: captures the finished sample's results on the last cycle and
// holds them; raises a one-clock strobe after each capture.
module ssc_result #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fin,
    input  logic         bit_in,
    input  logic [W-1:0] lvl_in,
    input  logic         bv_in,
    input  logic         lv_in,
    input  logic         cal_in,
    output logic         bit_q,
    output logic [W-1:0] lvl_q,
    output logic         bv_q,
    output logic         lv_q,
    output logic         cal_q,
    output logic         stb_q
);
    // Capture on finish, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            lvl_q <= '0;
            bv_q  <= 1'b0;
            lv_q  <= 1'b0;
            cal_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= fin;
            if (fin) begin
                bit_q <= bit_in;
                lvl_q <= lvl_in;
                bv_q  <= bv_in;
                lv_q  <= lv_in;
                cal_q <= cal_in;
            end
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> ($stable(bit_q) && $stable(lvl_q) && $stable(bv_q) && $stable(lv_q) && $stable(cal_q)));
endmodule

// File: rtl/spec_sar_ctrl.sv
// Speculative dual-threshold SAR controller for one two-comparator sub-converter.
// Loads two predicted thresholds per sample, resolves the bit when the
// comparators agree, refines the matching threshold for the level, and
// latches the results after a fixed number of evaluation cycles.
// Assumes sample_start is a one-clock pulse and the sample is held for the period.
module spec_sar_ctrl import ssc_pkg::*; #(
    parameter int W    = 5,
    parameter int NCYC = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_start,
    input  logic [W-1:0] spec_one,
    input  logic [W-1:0] spec_zero,
    input  logic         cmp_hi,
    input  logic         cmp_lo,
    output logic [W-1:0] dac_hi,
    output logic [W-1:0] dac_lo,
    output logic         bit_out,
    output logic [W-1:0] level_out,
    output logic         bit_valid,
    output logic         level_valid,
    output logic         cal_req,
    output logic         result_stb
);
    localparam int NPATH = 2;   // index 0: bit-1 path, index 1: bit-0 path

    logic [W-1:0] seeds [NPATH];
    logic [W-1:0] codes [NPATH];
    step_e        steps [NPATH];
    logic         eval_en, last;
    logic         nx_rec, nx_bit, nx_dig;
    logic [W-1:0] nx_lvl;
    logic [W:0]   code_sum;
    logic         fin_bit;
    logic [W-1:0] fin_lvl;

    assign seeds[0] = spec_one;
    assign seeds[1] = spec_zero;

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        ssc_thresh_reg #(.W(W)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (sample_start),
            .load_val (seeds[p]),
            .step     (steps[p]),
            .code     (codes[p])
        );
    end

    ssc_cycle_ctr #(.NCYC(NCYC)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sample_start),
        .eval_en (eval_en),
        .last    (last)
    );

    ssc_decide #(.W(W)) u_decide (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sample_start),
        .eval_en (eval_en),
        .c_hi    (cmp_hi),
        .c_lo    (cmp_lo),
        .code_hi (codes[0]),
        .code_lo (codes[1]),
        .step_hi (steps[0]),
        .step_lo (steps[1]),
        .nx_rec  (nx_rec),
        .nx_bit  (nx_bit),
        .nx_dig  (nx_dig),
        .nx_lvl  (nx_lvl)
    );

    // Final bit and level, with midpoint fallbacks for unresolved samples.
    always_comb begin
        code_sum = {1'b0, codes[0]} + {1'b0, codes[1]};
        fin_bit  = nx_rec ? nx_bit : code_sum[W];
        if (nx_dig)      fin_lvl = nx_lvl;
        else if (nx_rec) fin_lvl = nx_bit ? codes[0] : codes[1];
        else             fin_lvl = code_sum[W:1];
    end

    ssc_result #(.W(W)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .fin    (last),
        .bit_in (fin_bit),
        .lvl_in (fin_lvl),
        .bv_in  (nx_rec),
        .lv_in  (nx_dig),
        .cal_in (!nx_dig),
        .bit_q  (bit_out),
        .lvl_q  (level_out),
        .bv_q   (bit_valid),
        .lv_q   (level_valid),
        .cal_q  (cal_req),
        .stb_q  (result_stb)
    );

    assign dac_hi = codes[0];
    assign dac_lo = codes[1];

    // R7
    unresolved_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_stb && !bit_valid) |-> (cal_req && !level_valid));
    // R12
    load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_start |=> (dac_hi == $past(spec_one) && dac_lo == $past(spec_zero)));
endmodule

// File: tb/test_spec_sar_ctrl.sv
`timescale 1ns/1ps
module test_spec_sar_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_start = 1'b0;
    logic [4:0] spec_one = '0, spec_zero = '0;
    logic [4:0] xs = '0;          // held analog sample, as a code
    logic       cmp_hi, cmp_lo;
    logic [4:0] dac_hi, dac_lo, level_out;
    logic       bit_out, bit_valid, level_valid, cal_req, result_stb;
    int         nchk = 0, nfail = 0;
    bit         ended = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Ideal comparators: 1 when the held sample is at or above the code.
    assign cmp_hi = (xs >= dac_hi);
    assign cmp_lo = (xs >= dac_lo);

    spec_sar_ctrl i_spec_sar_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_start(sample_start),
        .spec_one(spec_one), .spec_zero(spec_zero),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
        .dac_hi(dac_hi), .dac_lo(dac_lo),
        .bit_out(bit_out), .level_out(level_out),
        .bit_valid(bit_valid), .level_valid(level_valid),
        .cal_req(cal_req), .result_stb(result_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sequential reading of the requirements over five evaluation cycles.
    function automatic void model(input int s1, input int s0, input int x,
                                  output int eb, output int el, output int ebv,
                                  output int elv, output int ec);
        int h, l, lvl, nh, nl;
        bit rec, bt, dig, c1, c2;
        h = s1; l = s0; rec = 0; bt = 0; dig = 0; lvl = 0;
        eb = 0; el = 0; ebv = 0; elv = 0; ec = 0;
        for (int c = 1; c <= 5; c++) begin
            c1 = (x >= h);
            c2 = (x >= l);
            nh = h; nl = l;
            if (!rec) begin
                if (c1 && c2)        begin rec = 1; bt = 1; nh = h + 1; end
                else if (!c1 && !c2) begin rec = 1; bt = 0; nl = l - 1; end
                else if (!c1 && c2)  begin nh = h - 1; nl = l + 1; end
            end else if (!dig) begin
                if (bt) begin
                    if (!c1) begin dig = 1; lvl = h; end else nh = h + 1;
                end else begin
                    if (c2) begin dig = 1; lvl = l; end else nl = l - 1;
                end
            end
            if (nh > 31) nh = 31;
            if (nh < 0)  nh = 0;
            if (nl > 31) nl = 31;
            if (nl < 0)  nl = 0;
            if (c == 5) begin
                ebv = rec; elv = dig; ec = !dig;
                eb  = rec ? bt : ((h + l) >= 32);
                el  = dig ? lvl : (rec ? (bt ? h : l) : (h + l) / 2);
            end
            h = nh; l = nl;
        end
    endfunction

    task automatic check_result(input string req, input int s1, input int s0, input int x);
        int eb, el, ebv, elv, ec;
        model(s1, s0, x, eb, el, ebv, elv, ec);
        chk({req, " bit"},   bit_out, eb);
        chk({req, " level"}, level_out, el);
        chk({req, " bit_valid"}, bit_valid, ebv);
        chk({req, " level_valid"}, level_valid, elv);
        chk({req, " cal_req"}, cal_req, ec);
    endtask

    // Called at a negedge; runs one isolated sample and checks its results.
    task automatic do_sample(input int s1, input int s0, input int x, input string req);
        spec_one = 5'(s1); spec_zero = 5'(s0); sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0; xs = 5'(x);
        repeat (5) @(negedge clk);
        check_result(req, s1, s0, x);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dac_hi", dac_hi, 0);
        chk("R1 dac_lo", dac_lo, 0);
        chk("R1 outputs", {bit_out, level_out, bit_valid, level_valid, cal_req, result_stb}, 0);

        // R2, R4, R8: between the thresholds for all five cycles
        spec_one = 5'd20; spec_zero = 5'd10; sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0; xs = 5'd15;
        chk("R2 dac_hi seed", dac_hi, 20);
        chk("R2 dac_lo seed", dac_lo, 10);
        @(negedge clk);
        chk("R4 dac_hi down", dac_hi, 19);
        chk("R4 dac_lo up", dac_lo, 11);
        repeat (4) @(negedge clk);
        chk("R8 bit midpoint", bit_out, 0);
        chk("R8 level midpoint", level_out, 15);
        chk("R8 bit_valid", bit_valid, 0);
        chk("R7 cal_req", cal_req, 1);
        chk("R10 strobe", result_stb, 1);
        @(negedge clk);
        chk("R10 strobe drop", result_stb, 0);
        chk("R10 level held", level_out, 15);

        // R3, R5, R6: bit 1 then refine the upper path
        spec_one = 5'd10; spec_zero = 5'd5; sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0; xs = 5'd12;
        @(negedge clk);
        chk("R5 dac_hi up", dac_hi, 11);
        chk("R5 dac_lo held", dac_lo, 5);
        repeat (4) @(negedge clk);
        chk("R3 bit one", bit_out, 1);
        chk("R6 level", level_out, 13);
        chk("R6 level_valid", level_valid, 1);

        // R4 crossed comparators: neither code moves
        spec_one = 5'd8; spec_zero = 5'd20; sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0; xs = 5'd12;
        @(negedge clk);
        chk("R4 crossed hi", dac_hi, 8);
        chk("R4 crossed lo", dac_lo, 20);
        repeat (4) @(negedge clk);
        check_result("R8 crossed", 8, 20, 12);

        // R9 saturation at the top code
        do_sample(30, 0, 31, "R9 sat");
        chk("R9 dac_hi top", dac_hi, 31);

        // R12 back-to-back: new start on the fifth-cycle edge
        spec_one = 5'd10; spec_zero = 5'd5; sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0; xs = 5'd12;
        repeat (4) @(negedge clk);
        spec_one = 5'd14; spec_zero = 5'd12; sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0;
        check_result("R12 first", 10, 5, 12);
        chk("R12 reload hi", dac_hi, 14);
        chk("R12 reload lo", dac_lo, 12);
        repeat (5) @(negedge clk);
        check_result("R12 second", 14, 12, 12);

        // R11 abort mid-sample: outputs keep the previous result
        spec_one = 5'd20; spec_zero = 5'd10; sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0; xs = 5'd12;
        repeat (2) @(negedge clk);
        spec_one = 5'd16; spec_zero = 5'd16; sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0;
        chk("R11 no strobe", result_stb, 0);
        check_result("R11 held", 14, 12, 12);
        repeat (5) @(negedge clk);
        check_result("R11 restarted", 16, 16, 12);

        // R3 R5 R6 R7 R8 R9 sweep over seeds and every sample code
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                for (int x = 0; x < 32; x++) begin
                    do_sample((i * 3 > 31) ? 31 : i * 3, (j * 3 > 31) ? 31 : j * 3, x, "R6 sweep");
                end
            end
        end

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule